// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to a simple in-order pipeline and decides, every clock, whether the core must leave its normal instruction stream. It watches the address of the instruction about to retire, three hardware-error lines, six synchronous fault lines raised by the execute stage, and six external interrupt lines. Each interrupt line has its own mask bit, and a global enable sits over all six. When a request is accepted, the block records a return address, stores a 5-bit reason code, forces the core into kernel mode and issues a one-cycle redirect carrying the handler's entry address.

Handler addresses are fixed 64-bit values, sign-extended from a 32-bit boot segment base. Each request class has its own offset from that base. Software leaves a handler through a return pulse. That pulse makes the block redirect fetch to the saved return address and puts the core back in user mode. All outputs come from registers and change on the clock edge after the inputs that cause them. Reset is synchronous and active high, and it is treated as the highest-priority exception.

Top module: `exc_entry_ctrl`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `kernel_o`=1, `cause_code_o`=0, `cause_pend_o`=0, `epc_o`=0, `redirect_o`=1 and `fetch_addr_o`=0xFFFF_FFFF_BFC0_0000.
- R2: If any bit of `hw_err_i` is high, the next cycle shows `redirect_o`=1, `fetch_addr_o`=0xFFFF_FFFF_BFC0_0300, `cause_code_o`=6, `epc_o`=`pc_i` and `kernel_o`=1. This happens whatever the other request lines carry.
- R3: When no hardware error is present and `sync_req_i` is nonzero, the lowest set bit wins. Bit 0 is address error (code 4), bit 1 is reserved instruction (10), bit 2 is overflow (12), bit 3 is trap (13), bit 4 is system call (8) and bit 5 is breakpoint (9). Fetch goes to 0xFFFF_FFFF_BFC0_0400, and `kernel_o` becomes 1.
- R4: The winning fault on bits 0 to 2 saves `pc_i` into `epc_o`. The winning fault on bits 3 to 5 saves `pc_i`+4.
- R5: An interrupt is taken when all of the following hold: `kernel_o` is 0, `irq_en_i` is 1, `irq_i & irq_mask_i` is nonzero, and no hardware error or fault is requested. It then gives fetch 0xFFFF_FFFF_BFC0_0380, code 0, `epc_o`=`pc_i` and `kernel_o`=1.
- R6: Interrupt lines cause no redirect and leave `kernel_o`, `epc_o` and `cause_code_o` unchanged in any of these cases: in kernel mode, when the global enable is low, or when every active line is masked.
- R7: `cause_pend_o` shows the raw `irq_i` from the previous clock edge, whatever the mask and enable settings.
- R8: A high `eret_i` with no exception taken on the same edge gives, in the next cycle, `redirect_o`=1, `fetch_addr_o` equal to `epc_o`, and `kernel_o`=0. `epc_o` is unchanged.
- R9: `eret_i` has no effect on an edge where an exception is taken. The entry result of R2, R3 or R5 appears instead, with `kernel_o`=1.
- R10: An edge that takes no exception and has no return leaves `redirect_o`=0 in the next cycle and holds `kernel_o`, `epc_o` and `cause_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, taken as the reset exception |
| pc_i | input | AW (64) | Address of the instruction at the commit point |
| hw_err_i | input | NHW (3) | Hardware error requests: bus check, bus error, cache error |
| sync_req_i | input | 6 | Synchronous fault requests, bit order as in R3 |
| irq_i | input | NIRQ (6) | External interrupt lines |
| irq_mask_i | input | NIRQ (6) | Per-line interrupt enable bits |
| irq_en_i | input | 1 | Global interrupt enable |
| eret_i | input | 1 | Return-from-exception pulse |
| kernel_o | output | 1 | 1 while the core runs in kernel mode |
| epc_o | output | AW (64) | Saved return address |
| cause_code_o | output | 5 | Reason code of the last exception |
| cause_pend_o | output | NIRQ (6) | Interrupt lines seen on the previous edge |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| fetch_addr_o | output | AW (64) | Redirect target, valid while `redirect_o` is 1 |

## Verification
The properties assume that `pc_i` is a real instruction address and that `eret_i` is only raised while a handler runs. Return checks are therefore only claimed from kernel mode. Faults and hardware errors may arrive in any mode and in any combination.

The stimulus respects these assumptions. It puts the core into user mode with a return pulse before every fault or interrupt case. It sweeps every nonzero fault pattern and every hardware-error pattern. It also sweeps all interrupt patterns against several mask and enable settings, with the expected result computed from a model of the mode bit and the saved return address.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int unsigned NSYNC = 6;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_HW   = 2'd1,
    CLS_SYNC = 2'd2,
    CLS_IRQ  = 2'd3
  } exc_cls_e;

  typedef enum logic [4:0] {
    EC_INT  = 5'd0,
    EC_ADDR = 5'd4,
    EC_BUS  = 5'd6,
    EC_SYS  = 5'd8,
    EC_BRK  = 5'd9,
    EC_RSVD = 5'd10,
    EC_OVF  = 5'd12,
    EC_TRAP = 5'd13
  } exc_code_e;

  localparam logic [31:0] BOOT_BASE  = 32'hBFC0_0000;
  localparam logic [11:0] OFS_RESET  = 12'h000;
  localparam logic [11:0] OFS_HW     = 12'h300;
  localparam logic [11:0] OFS_IRQ    = 12'h380;
  localparam logic [11:0] OFS_GEN    = 12'h400;

  // reason code for a fault line, index = priority position
  function automatic exc_code_e sync_code(input int idx);
    case (idx)
      0:       return EC_ADDR;
      1:       return EC_RSVD;
      2:       return EC_OVF;
      3:       return EC_TRAP;
      4:       return EC_SYS;
      default: return EC_BRK;
    endcase
  endfunction

  // lines that resume after the requesting instruction
  function automatic logic sync_resumes_after(input int idx);
    return (idx >= 3);
  endfunction

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int unsigned NIRQ = 6
) (
  input  logic [NIRQ-1:0] irq_i,
  input  logic [NIRQ-1:0] mask_i,
  input  logic            en_i,
  input  logic            kernel_i,
  output logic            hit_o
);

  logic [NIRQ-1:0] live;

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    assign live[g] = irq_i[g] & mask_i[g];
  end

  assign hit_o = en_i & ~kernel_i & (|live);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int unsigned NHW = 3
) (
  input  logic [NHW-1:0]   hw_i,
  input  logic [NSYNC-1:0] sync_i,
  input  logic             irq_hit_i,
  output exc_cls_e         cls_o,
  output exc_code_e        code_o,
  output logic             after_o
);

  exc_code_e sync_pick;
  logic      sync_after;

  // walk from the lowest priority upward so the lowest index wins
  always_comb begin
    sync_pick  = EC_ADDR;
    sync_after = 1'b0;
    for (int i = NSYNC - 1; i >= 0; i--) begin
      if (sync_i[i]) begin
        sync_pick  = sync_code(i);
        sync_after = sync_resumes_after(i);
      end
    end
  end

  always_comb begin
    cls_o   = CLS_NONE;
    code_o  = EC_INT;
    after_o = 1'b0;
    if (|hw_i) begin
      cls_o  = CLS_HW;
      code_o = EC_BUS;
    end else if (|sync_i) begin
      cls_o   = CLS_SYNC;
      code_o  = sync_pick;
      after_o = sync_after;
    end else if (irq_hit_i) begin
      cls_o  = CLS_IRQ;
      code_o = EC_INT;
    end
  end

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int unsigned AW   = 64,
  parameter int unsigned NIRQ = 6,
  parameter logic [AW-1:0] VEC_RESET = '0,
  parameter logic [AW-1:0] VEC_HW    = '0,
  parameter logic [AW-1:0] VEC_GEN   = '0,
  parameter logic [AW-1:0] VEC_IRQ   = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  exc_cls_e        cls_i,
  input  exc_code_e       code_i,
  input  logic            after_i,
  input  logic [AW-1:0]   pc_i,
  input  logic            eret_i,
  input  logic [NIRQ-1:0] irq_i,
  output logic            kernel_o,
  output logic [AW-1:0]   epc_o,
  output logic [4:0]      code_o,
  output logic [NIRQ-1:0] pend_o,
  output logic            redirect_o,
  output logic [AW-1:0]   fetch_o
);

  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  logic [AW-1:0] target;
  logic [AW-1:0] ret_addr;

  always_comb begin
    case (cls_i)
      CLS_HW:   target = VEC_HW;
      CLS_SYNC: target = VEC_GEN;
      default:  target = VEC_IRQ;
    endcase
  end

  assign ret_addr = after_i ? (pc_i + INSN_BYTES) : pc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      kernel_o   <= 1'b1;
      epc_o      <= '0;
      code_o     <= EC_INT;
      pend_o     <= '0;
      redirect_o <= 1'b1;
      fetch_o    <= VEC_RESET;
    end else begin
      pend_o     <= irq_i;
      redirect_o <= 1'b0;
      if (cls_i != CLS_NONE) begin
        kernel_o   <= 1'b1;
        epc_o      <= ret_addr;
        code_o     <= code_i;
        redirect_o <= 1'b1;
        fetch_o    <= target;
      end else if (eret_i) begin
        kernel_o   <= 1'b0;
        redirect_o <= 1'b1;
        fetch_o    <= epc_o;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned AW   = 64,
  parameter int unsigned NIRQ = 6,
  parameter int unsigned NHW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           pc_i,
  input  logic [NHW-1:0]          hw_err_i,
  input  logic [exc_pkg::NSYNC-1:0] sync_req_i,
  input  logic [NIRQ-1:0]         irq_i,
  input  logic [NIRQ-1:0]         irq_mask_i,
  input  logic                    irq_en_i,
  input  logic                    eret_i,
  output logic                    kernel_o,
  output logic [AW-1:0]           epc_o,
  output logic [4:0]              cause_code_o,
  output logic [NIRQ-1:0]         cause_pend_o,
  output logic                    redirect_o,
  output logic [AW-1:0]           fetch_addr_o
);

  localparam int unsigned EXT = AW - 32;
  localparam logic [AW-1:0] VEC_RESET = {{EXT{BOOT_BASE[31]}}, BOOT_BASE | {20'd0, OFS_RESET}};
  localparam logic [AW-1:0] VEC_HW    = {{EXT{BOOT_BASE[31]}}, BOOT_BASE | {20'd0, OFS_HW}};
  localparam logic [AW-1:0] VEC_IRQ   = {{EXT{BOOT_BASE[31]}}, BOOT_BASE | {20'd0, OFS_IRQ}};
  localparam logic [AW-1:0] VEC_GEN   = {{EXT{BOOT_BASE[31]}}, BOOT_BASE | {20'd0, OFS_GEN}};

  logic      irq_hit;
  exc_cls_e  cls;
  exc_code_e code;
  logic      after;

  exc_irq_gate #(.NIRQ(NIRQ)) u_gate (
    .irq_i    (irq_i),
    .mask_i   (irq_mask_i),
    .en_i     (irq_en_i),
    .kernel_i (kernel_o),
    .hit_o    (irq_hit)
  );

  exc_arbiter #(.NHW(NHW)) u_arb (
    .hw_i      (hw_err_i),
    .sync_i    (sync_req_i),
    .irq_hit_i (irq_hit),
    .cls_o     (cls),
    .code_o    (code),
    .after_o   (after)
  );

  exc_state #(
    .AW(AW), .NIRQ(NIRQ),
    .VEC_RESET(VEC_RESET), .VEC_HW(VEC_HW), .VEC_GEN(VEC_GEN), .VEC_IRQ(VEC_IRQ)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .cls_i      (cls),
    .code_i     (code),
    .after_i    (after),
    .pc_i       (pc_i),
    .eret_i     (eret_i),
    .irq_i      (irq_i),
    .kernel_o   (kernel_o),
    .epc_o      (epc_o),
    .code_o     (cause_code_o),
    .pend_o     (cause_pend_o),
    .redirect_o (redirect_o),
    .fetch_o    (fetch_addr_o)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int unsigned AW   = 64,
  parameter int unsigned NIRQ = 6,
  parameter int unsigned NHW  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   pc_i,
  input logic [NHW-1:0]  hw_err_i,
  input logic [NSYNC-1:0] sync_req_i,
  input logic [NIRQ-1:0] irq_i,
  input logic [NIRQ-1:0] irq_mask_i,
  input logic            irq_en_i,
  input logic            eret_i,
  input logic            kernel_o,
  input logic [AW-1:0]   epc_o,
  input logic [4:0]      cause_code_o,
  input logic            redirect_o,
  input logic [AW-1:0]   fetch_addr_o
);

  localparam logic [AW-1:0] C_RESET = {{(AW-32){1'b1}}, 32'hBFC0_0000};
  localparam logic [AW-1:0] C_HW    = {{(AW-32){1'b1}}, 32'hBFC0_0300};
  localparam logic [AW-1:0] C_IRQ   = {{(AW-32){1'b1}}, 32'hBFC0_0380};

  logic no_fault;
  assign no_fault = (hw_err_i == '0) && (sync_req_i == '0);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (kernel_o && cause_code_o == 5'd0 && epc_o == '0 && redirect_o && fetch_addr_o == C_RESET)); // R1

  AST_HWERR_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (|hw_err_i) |=> (redirect_o && kernel_o && fetch_addr_o == C_HW && cause_code_o == 5'd6 && epc_o == $past(pc_i))); // R2

  AST_ADDR_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    (hw_err_i == '0 && sync_req_i[0]) |=> (kernel_o && cause_code_o == 5'd4 && epc_o == $past(pc_i))); // R3

  AST_SYSCALL_EPC: assert property (@(posedge clk) disable iff (rst)
    (hw_err_i == '0 && sync_req_i == 6'b010000) |=> (cause_code_o == 5'd8 && epc_o == $past(pc_i) + AW'(4))); // R4

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (no_fault && !kernel_o && irq_en_i && |(irq_i & irq_mask_i)) |=> (fetch_addr_o == C_IRQ && cause_code_o == 5'd0 && kernel_o)); // R5

  AST_KERNEL_IRQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (no_fault && kernel_o && !eret_i) |=> (!redirect_o && kernel_o && $stable(epc_o) && $stable(cause_code_o))); // R6

  AST_ERET_RETURN: assert property (@(posedge clk) disable iff (rst)
    (no_fault && kernel_o && eret_i) |=> (redirect_o && !kernel_o && fetch_addr_o == $past(epc_o) && $stable(epc_o))); // R8

  AST_ERET_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (eret_i && !no_fault) |=> (kernel_o && redirect_o)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (no_fault && !eret_i && irq_i == '0) |=> (!redirect_o && $stable(kernel_o) && $stable(epc_o))); // R10

endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .NIRQ(NIRQ), .NHW(NHW)) u_chk (
  .clk(clk), .rst(rst), .pc_i(pc_i), .hw_err_i(hw_err_i), .sync_req_i(sync_req_i),
  .irq_i(irq_i), .irq_mask_i(irq_mask_i), .irq_en_i(irq_en_i), .eret_i(eret_i),
  .kernel_o(kernel_o), .epc_o(epc_o), .cause_code_o(cause_code_o),
  .redirect_o(redirect_o), .fetch_addr_o(fetch_addr_o)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

  localparam int AW = 64;
  localparam int NIRQ = 6;
  localparam int NHW = 3;
  localparam logic [63:0] V_RESET = 64'hFFFF_FFFF_BFC0_0000;
  localparam logic [63:0] V_HW    = 64'hFFFF_FFFF_BFC0_0300;
  localparam logic [63:0] V_IRQ   = 64'hFFFF_FFFF_BFC0_0380;
  localparam logic [63:0] V_GEN   = 64'hFFFF_FFFF_BFC0_0400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] pc_i = '0;
  logic [NHW-1:0] hw_err_i = '0;
  logic [5:0] sync_req_i = '0;
  logic [NIRQ-1:0] irq_i = '0;
  logic [NIRQ-1:0] irq_mask_i = '0;
  logic irq_en_i = 1'b0;
  logic eret_i = 1'b0;
  logic kernel_o;
  logic [AW-1:0] epc_o;
  logic [4:0] cause_code_o;
  logic [NIRQ-1:0] cause_pend_o;
  logic redirect_o;
  logic [AW-1:0] fetch_addr_o;

  int total = 0;
  int bad = 0;
  logic m_kernel;
  logic [63:0] m_epc;
  logic [4:0] m_code;

  exc_entry_ctrl #(.AW(AW), .NIRQ(NIRQ), .NHW(NHW)) uut (
    .clk(clk), .rst(rst), .pc_i(pc_i), .hw_err_i(hw_err_i), .sync_req_i(sync_req_i),
    .irq_i(irq_i), .irq_mask_i(irq_mask_i), .irq_en_i(irq_en_i), .eret_i(eret_i),
    .kernel_o(kernel_o), .epc_o(epc_o), .cause_code_o(cause_code_o),
    .cause_pend_o(cause_pend_o), .redirect_o(redirect_o), .fetch_addr_o(fetch_addr_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] fault_code(input int idx);
    case (idx)
      0: return 5'd4;
      1: return 5'd10;
      2: return 5'd12;
      3: return 5'd13;
      4: return 5'd8;
      default: return 5'd9;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    hw_err_i = '0; sync_req_i = '0; irq_i = '0; eret_i = 1'b0;
    @(posedge clk); #1;
    check("R1", "kernel", 64'(kernel_o), 64'd1);
    check("R1", "code", 64'(cause_code_o), 64'd0);
    check("R1", "pend", 64'(cause_pend_o), 64'd0);
    check("R1", "epc", epc_o, 64'd0);
    check("R1", "redirect", 64'(redirect_o), 64'd1);
    check("R1", "fetch", fetch_addr_o, V_RESET);
    @(negedge clk);
    rst = 1'b0;
    m_kernel = 1'b1; m_epc = '0; m_code = '0;
  endtask

  task automatic step(input logic [NHW-1:0] hw, input logic [5:0] sy, input logic [5:0] iq,
                      input logic [5:0] mk, input logic ge, input logic er, input logic [63:0] pc);
    logic hit;
    logic e_red;
    logic e_kern;
    logic [63:0] e_fetch;
    logic [63:0] e_epc;
    logic [4:0] e_code;
    string tg;
    int idx;
    hit = !m_kernel && ge && ((iq & mk) != 0);
    e_red = 1'b1; e_kern = 1'b1; e_epc = m_epc; e_code = m_code; e_fetch = '0;
    if (hw != 0) begin
      tg = "R2"; e_fetch = V_HW; e_code = 5'd6; e_epc = pc;
    end else if (sy != 0) begin
      idx = 0;
      for (int i = 5; i >= 0; i--) if (sy[i]) idx = i;
      tg = (idx >= 3) ? "R3/R4+4" : "R3/R4";
      e_fetch = V_GEN; e_code = fault_code(idx);
      e_epc = (idx >= 3) ? pc + 64'd4 : pc;
    end else if (hit) begin
      tg = "R5"; e_fetch = V_IRQ; e_code = 5'd0; e_epc = pc;
    end else if (er) begin
      tg = "R8"; e_fetch = m_epc; e_kern = 1'b0;
    end else begin
      tg = (iq != 0) ? "R6" : "R10"; e_red = 1'b0; e_kern = m_kernel;
    end
    if (er && (hw != 0 || sy != 0 || hit)) tg = {tg, "/R9"};
    @(negedge clk);
    hw_err_i = hw; sync_req_i = sy; irq_i = iq; irq_mask_i = mk;
    irq_en_i = ge; eret_i = er; pc_i = pc;
    @(posedge clk); #1;
    check(tg, "redirect", 64'(redirect_o), 64'(e_red));
    check(tg, "kernel", 64'(kernel_o), 64'(e_kern));
    check(tg, "epc", epc_o, e_epc);
    check(tg, "code", 64'(cause_code_o), 64'(e_code));
    check("R7", "pend", 64'(cause_pend_o), 64'(iq));
    if (e_red) check(tg, "fetch", fetch_addr_o, e_fetch);
    m_kernel = e_kern; m_epc = e_epc; m_code = e_code;
  endtask

  task automatic to_user();
    if (m_kernel) step('0, '0, '0, '0, 1'b0, 1'b1, 64'h0);
  endtask

  initial begin
    do_reset();
    // R8 from reset: return to address 0
    step('0, '0, '0, '0, 1'b0, 1'b1, 64'h10);
    // R3, R4: every fault pattern, interrupts pending to show lower priority
    for (int s = 1; s < 64; s++) begin
      to_user();
      step('0, 6'(s), 6'h3F, 6'h3F, 1'b1, 1'b0, 64'h0000_0000_0040_0000 + 64'(s * 16));
    end
    // R2, R9: every hardware error pattern, with faults and return asserted
    for (int h = 1; h < 8; h++) begin
      to_user();
      step(3'(h), 6'(h * 9), 6'h3F, 6'h3F, 1'b1, 1'b1, 64'h0000_0000_1000_0000 + 64'(h * 4));
    end
    // R9 with a fault
    to_user();
    step('0, 6'h10, '0, '0, 1'b0, 1'b1, 64'h2000);
    // R5, R6: interrupt lines against masks and enable
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 2; g++) begin
        for (int q = 0; q < 64; q++) begin
          logic [5:0] mk;
          mk = (m == 0) ? 6'h3F : (m == 1) ? 6'h15 : (m == 2) ? 6'h2A : 6'h00;
          to_user();
          step('0, '0, 6'(q), mk, g[0], 1'b0, 64'h0000_0000_3000_0000 + 64'(q * 4));
        end
      end
    end
    // R6: kernel mode ignores interrupts; R10: idle holds
    step('0, 6'h01, '0, '0, 1'b0, 1'b0, 64'h4000);
    step('0, '0, 6'h3F, 6'h3F, 1'b1, 1'b0, 64'h4100);
    step('0, '0, '0, '0, 1'b0, 1'b0, 64'h4200);
    to_user();
    step('0, '0, '0, 6'h3F, 1'b1, 1'b0, 64'h4300);
    // R1 again mid-run
    do_reset();
    step('0, '0, '0, '0, 1'b0, 1'b0, 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule